// File: doc/BRIEF.md
# Quadrature Divide-by-Four Clock Generator

This block takes one input clock and delivers two square waves, an in-phase wave and a quadrature wave, each at one quarter of the input rate. The quadrature wave trails the in-phase wave by a quarter of the output period, which is 90 degrees. Both waves come from a two-bit twisted ring. Both of its registers update on the same clock edge, so the two phases appear together and no stage is clocked by another stage.

For low-band use, a prescaler can sit in front of the ring. It is a chain of toggle stages, two by default, which divides by four. Its terminal count acts as a clock enable for the ring, so the overall division becomes sixteen. The prescale choice is sampled only while reset is held. A one-cycle strobe marks each return of the ring to its starting state, so a downstream sampler can pair up I and Q samples.

Top module: `quad_div4_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, both phase outputs and `wrap_o` are 0 after that edge, and the prescaler restarts from zero.
- R2: In direct mode (`lowband_i` was 0 during reset), the pair (`ph_i_o`,`ph_q_o`) after the n-th rising edge following reset release follows the repeating order 00, 10, 11, 01 indexed by n mod 4.
- R3: Each output is high for exactly two ring steps and low for two, so it has 50% duty at one quarter of the step rate.
- R4: After each ring step, `ph_q_o` equals the value `ph_i_o` had before that step, which is a lag of one step (90 degrees).
- R5: Across any rising edge that is not a reset edge, at most one of the two phase outputs changes.
- R6: In low-band mode (`lowband_i` was 1 during reset), a two-stage toggle prescaler lets the ring step only on every fourth edge after reset release, starting with the 4th. The outputs therefore run at 1/16 of the clock.
- R7: `lowband_i` is sampled only on edges where `rst_i` is high. Changing it while reset is low has no effect on the outputs.
- R8: `wrap_o` is high for exactly one cycle, right after a ring step that brings the pair back to 00. It is never high after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all state updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| lowband_i | input | 1 | Prescale select (1 = divide by 16 overall), sampled during reset |
| ph_i_o | output | 1 | In-phase quarter-rate square wave |
| ph_q_o | output | 1 | Quadrature wave, lagging `ph_i_o` by 90 degrees |
| wrap_o | output | 1 | One-cycle strobe on each return to state 00 |

## Verification
The bench builds the block with its default of two prescaler stages. A complete low-band output period is then only sixteen clocks long, so many full periods in both modes fit into short random segments. These segments use random reset lengths and random toggling of the prescale select while reset is low. Every cycle is compared against a step-count model that derives the ring index from the number of edges since reset release. Directed cases cover a one-cycle reset landing mid-sequence and switching between the two modes.

// File: rtl/quad_div4_pkg.sv
package quad_div4_pkg;

  // Ring state: i = in-phase output, q = quadrature output
  typedef struct packed {
    logic i;
    logic q;
  } qd_pair_t;

  localparam qd_pair_t QD_START = '{i: 1'b0, q: 1'b0};
  localparam qd_pair_t QD_LAST  = '{i: 1'b0, q: 1'b1};

  // One step of the twisted ring: i takes the inverse of q, q takes i.
  function automatic qd_pair_t qd_step(input qd_pair_t cur);
    qd_pair_t nxt;
    nxt.i = ~cur.q;
    nxt.q = cur.i;
    return nxt;
  endfunction

  // True when the next step lands on the start state.
  function automatic logic qd_closes(input qd_pair_t cur);
    return cur == QD_LAST;
  endfunction

endpackage

// File: rtl/quad_div4_prescale.sv
module quad_div4_prescale #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tc_o
);
  logic [STAGES:0]   en_chain;
  logic [STAGES-1:0] tog_all;

  assign en_chain[0] = 1'b1;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic t_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)            t_q <= 1'b0;
        else if (en_chain[k]) t_q <= ~t_q;
      end
      assign en_chain[k+1] = en_chain[k] & t_q;
      assign tog_all[k]    = t_q;
    end
  endgenerate

  assign tc_o = en_chain[STAGES];

  // R6
  pre_wraps_to_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o |=> (tog_all == '0));

  // R1
  pre_reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (tog_all == '0));
endmodule

// File: rtl/quad_div4_ring.sv
module quad_div4_ring
  import quad_div4_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     adv_i,
  output qd_pair_t pair_o,
  output logic     wrap_o
);
  qd_pair_t st_q;
  logic     wrap_q;
  logic     closing;

  assign closing = adv_i & qd_closes(st_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= QD_START;
      wrap_q <= 1'b0;
    end else begin
      if (adv_i) st_q <= qd_step(st_q);
      wrap_q <= closing;
    end
  end

  assign pair_o = st_q;
  assign wrap_o = wrap_q;

  // R4
  q_lags_i_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !rst_i) |=> (st_q.q == $past(st_q.i)));

  // R5
  gray_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ($countones(st_q ^ $past(st_q)) <= 1));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!adv_i && !rst_i) |=> $stable(st_q));

  // R8
  wrap_at_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_q |-> (st_q == QD_START));

  // R8
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_q |=> !wrap_q);
endmodule

// File: rtl/quad_div4_gen.sv
module quad_div4_gen
  import quad_div4_pkg::*;
#(
  parameter int PRE_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lowband_i,
  output logic ph_i_o,
  output logic ph_q_o,
  output logic wrap_o
);
  logic     lowband_q;
  logic     pre_tc;
  logic     ring_adv;
  qd_pair_t pair;

  // Mode is captured only while reset is held.
  always_ff @(posedge clk_i) begin
    if (rst_i) lowband_q <= lowband_i;
  end

  quad_div4_prescale #(.STAGES(PRE_STAGES)) u_pre (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tc_o  (pre_tc)
  );

  assign ring_adv = lowband_q ? pre_tc : 1'b1;

  quad_div4_ring u_ring (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .adv_i  (ring_adv),
    .pair_o (pair),
    .wrap_o (wrap_o)
  );

  assign ph_i_o = pair.i;
  assign ph_q_o = pair.q;

  // R7
  mode_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> $stable(lowband_q));

  // R1
  reset_outputs_chk: assert property (@(posedge clk_i)
    rst_i |=> (!ph_i_o && !ph_q_o && !wrap_o));
endmodule

// File: tb/test_quad_div4_gen.sv
module test_quad_div4_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lb  = 1'b0;
  logic ph_i, ph_q, wrap;

  int n_chk  = 0;
  int n_fail = 0;
  int edges  = 0;   // edges since reset release
  logic mode = 1'b0;
  logic prev_i = 1'b0, prev_q = 1'b0;
  logic prev_rst = 1'b1;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  quad_div4_gen i_quad_div4_gen (
    .clk_i(clk), .rst_i(rst), .lowband_i(lb),
    .ph_i_o(ph_i), .ph_q_o(ph_q), .wrap_o(wrap)
  );

  function automatic int steps(input int e, input logic m);
    return m ? e / 4 : e;
  endfunction
  function automatic logic exp_i(input int n);
    return (n % 4 == 1) || (n % 4 == 2);
  endfunction
  function automatic logic exp_q(input int n);
    return (n % 4) >= 2;
  endfunction
  function automatic logic exp_wrap(input int e, input logic m);
    logic stepped;
    stepped = m ? (e > 0 && e % 4 == 0) : (e > 0);
    return stepped && (steps(e, m) % 4 == 0);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (edges=%0d mode=%0b)", req, act, exp, edges, mode);
    end
  endtask

  task automatic cycle(input logic r, input logic l);
    int n;
    rst = r; lb = l;
    @(posedge clk);
    if (r) begin edges = 0; mode = l; end
    else edges++;
    @(negedge clk);
    n = steps(edges, mode);
    if (r) begin
      check("R1 ph_i", ph_i, 1'b0);
      check("R1 ph_q", ph_q, 1'b0);
      check("R1 wrap", wrap, 1'b0);
    end else begin
      check(mode ? "R6/R7 ph_i" : "R2/R3 ph_i", ph_i, exp_i(n));
      check(mode ? "R6/R7 ph_q" : "R2/R3 ph_q", ph_q, exp_q(n));
      check("R8 wrap", wrap, exp_wrap(edges, mode));
      if (!prev_rst) begin
        check("R5 gray", ($countones({ph_i ^ prev_i, ph_q ^ prev_q}) <= 1), 1'b1);
        if (ph_i != prev_i || ph_q != prev_q)
          check("R4 lag", ph_q, prev_i);
      end
    end
    prev_i = ph_i; prev_q = ph_q; prev_rst = r;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: reset state, direct mode
    repeat (3) cycle(1'b1, 1'b0);
    // R2 R3 R4 R5 R8: direct run
    repeat (40) cycle(1'b0, 1'b0);
    // R1: one-cycle reset mid-sequence, select low band
    cycle(1'b1, 1'b1);
    // R6: low-band run
    repeat (70) cycle(1'b0, 1'b1);
    // R7: select toggled while running low band, no effect
    repeat (40) cycle(1'b0, 1'(edges % 3 == 0));
    // R7: back to direct only through reset
    repeat (2) cycle(1'b1, 1'b0);
    repeat (30) cycle(1'b0, 1'b1);
    // random segments
    for (int s = 0; s < 40; s++) begin
      logic m;
      int rl, len;
      m   = 1'($urandom_range(1, 0));
      rl  = $urandom_range(3, 1);
      len = $urandom_range(120, 5);
      for (int k = 0; k < rl; k++) cycle(1'b1, m);
      for (int k = 0; k < len; k++) cycle(1'b0, 1'($urandom_range(1, 0)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule